// File: doc/BRIEF.md
# Dual Stack Pointer Register Unit

This unit keeps the two stack pointers of a processor core that runs in a privileged supervisor mode and an unprivileged user mode. Neither register is fixed to a mode. One register is always the live A7 that ordinary instructions use. The other register holds the pointer of the mode that is not running. When the dual-pointer enable is set and the supervisor bit changes, the two registers exchange contents in that same clock edge. The live A7 therefore always belongs to the current mode. When the enable is clear, only one stack pointer is in use and a mode change moves nothing.

The core reaches the unit through four paths:
- plain A7 reads and writes;
- two privileged moves, one that writes the user pointer and one that reads it;
- a debug path that names the live and inactive registers directly, without the mode mapping;
- a write strobe for the enable bit.

A user-pointer move made in user mode is refused and reported as a one-cycle privilege violation. All pins are plain control and data strobes that take effect in a single cycle. No data stream passes through the unit, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_sp_regs`

## Requirements
- R1: After reset, both registers hold zero, `dual_en` is 0 and `priv_viol` is 0.
- R2: `a7_rdata` always shows the live register. With `a7_we` high, `a7_wdata` is written into the live register at the clock edge.
- R3: While `dual_en` is 1, a change of `sup_i` against its value at the previous edge makes the registers exchange contents at that edge. In that cycle `a7_rdata` already shows the post-exchange value, and an A7 write lands in the post-exchange live register.
- R4: While `dual_en` is 0, a change of `sup_i` leaves both registers unchanged.
- R5: With `sup_i` = 1, `usp_rd_req` puts the inactive register (the user pointer) on `usp_rdata`, and `usp_wr_req` writes `usp_wdata` into the inactive register.
- R6: A `usp_wr_req` or `usp_rd_req` made with `sup_i` = 0 drives `priv_viol` high for exactly the next cycle and changes neither register.
- R7: The debug path applies no mode mapping. `dbg_rdata` shows the live register when `dbg_sel` = 0 and the inactive register when `dbg_sel` = 1. `dbg_we` writes `dbg_wdata` into the register selected in the same way.
- R8: If a debug write and a core write target the same register in the same cycle, the debug data wins.
- R9: A `cfg_we` pulse loads `cfg_eusp` into the enable, and the enable is visible on `dual_en` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_i | input | 1 | Supervisor bit of the status register (1 = supervisor) |
| cfg_we | input | 1 | Write strobe for the dual-pointer enable |
| cfg_eusp | input | 1 | New value of the dual-pointer enable |
| dual_en | output | 1 | Current dual-pointer enable |
| a7_we | input | 1 | Core write to the live A7 |
| a7_wdata | input | 32 | Core A7 write data |
| a7_rdata | output | 32 | Live A7 value, including any exchange made this cycle |
| usp_wr_req | input | 1 | Privileged move into the user pointer |
| usp_rd_req | input | 1 | Privileged move out of the user pointer |
| usp_wdata | input | 32 | Data for the move into the user pointer |
| usp_rdata | output | 32 | User pointer on a granted read, otherwise zero |
| priv_viol | output | 1 | One-cycle privilege-violation pulse |
| dbg_we | input | 1 | Debug write strobe |
| dbg_sel | input | 1 | Debug target: 0 = live register, 1 = inactive register |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Raw contents of the register chosen by `dbg_sel` |

## Verification
The hardest cases to reach are those where a mode change lands on the same edge as other traffic. Two of them matter most: an A7 write, and a read of the live pointer taken before the edge commits the exchange. The stimulus table writes A7 in a row where it also flips `sup_i`. The expected value is the written data in the live register, with the old live value moved to the inactive register. A directed step then flips `sup_i` and samples `a7_rdata` before the clock edge, where the inactive register's value must already appear. The debug path is read back after each row, so every exchange is checked through both registers, not only through the live one.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int unsigned SP_W = 32;
  localparam int unsigned N_SLOTS = 2;
  typedef enum logic {SLOT_LIVE = 1'b0, SLOT_IDLE = 1'b1} slot_e;
endpackage

// File: rtl/dsp_mode_track.sv
module dsp_mode_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_i,
  input  logic cfg_we,
  input  logic cfg_eusp,
  output logic dual_en,
  output logic swap
);
  logic sup_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      sup_q <= sup_i;
      if (cfg_we) en_q <= cfg_eusp;
    end
  end

  assign dual_en = en_q;
  assign swap    = en_q && (sup_i != sup_q);
endmodule

// File: rtl/dsp_priv_check.sv
module dsp_priv_check (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_i,
  input  logic usp_wr_req,
  input  logic usp_rd_req,
  output logic usp_wr_ok,
  output logic usp_rd_ok,
  output logic priv_viol
);
  logic bad;

  assign usp_wr_ok = usp_wr_req && sup_i;
  assign usp_rd_ok = usp_rd_req && sup_i;
  assign bad       = (usp_wr_req || usp_rd_req) && !sup_i;

  always_ff @(posedge clk) begin
    if (!rst_n) priv_viol <= 1'b0;
    else        priv_viol <= bad;
  end
endmodule

// File: rtl/dsp_regfile.sv
module dsp_regfile
  import dsp_pkg::*;
#(
  parameter int unsigned W = SP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         swap,
  input  logic         live_we,
  input  logic [W-1:0] live_wdata,
  input  logic         idle_we,
  input  logic [W-1:0] idle_wdata,
  input  logic         dbg_we,
  input  logic         dbg_sel,
  input  logic [W-1:0] dbg_wdata,
  output logic [W-1:0] live_q,
  output logic [W-1:0] idle_q,
  output logic [W-1:0] live_view,
  output logic [W-1:0] idle_view
);
  logic [W-1:0] cur  [N_SLOTS];
  logic [W-1:0] base [N_SLOTS];
  logic [W-1:0] nxt  [N_SLOTS];

  assign base[0] = swap ? cur[1] : cur[0];
  assign base[1] = swap ? cur[0] : cur[1];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic         core_we;
    logic [W-1:0] core_d;
    logic         dbg_hit;

    assign core_we = (i == 0) ? live_we    : idle_we;
    assign core_d  = (i == 0) ? live_wdata : idle_wdata;
    assign dbg_hit = dbg_we && (dbg_sel == 1'(i));

    always_comb begin
      nxt[i] = base[i];
      if (core_we) nxt[i] = core_d;
      if (dbg_hit) nxt[i] = dbg_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cur[i] <= '0;
      else        cur[i] <= nxt[i];
    end
  end

  assign live_q    = cur[0];
  assign idle_q    = cur[1];
  assign live_view = base[0];
  assign idle_view = base[1];
endmodule

// File: rtl/dual_sp_regs.sv
module dual_sp_regs
  import dsp_pkg::*;
#(
  parameter int unsigned W = SP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sup_i,
  input  logic         cfg_we,
  input  logic         cfg_eusp,
  output logic         dual_en,
  input  logic         a7_we,
  input  logic [W-1:0] a7_wdata,
  output logic [W-1:0] a7_rdata,
  input  logic         usp_wr_req,
  input  logic         usp_rd_req,
  input  logic [W-1:0] usp_wdata,
  output logic [W-1:0] usp_rdata,
  output logic         priv_viol,
  input  logic         dbg_we,
  input  logic         dbg_sel,
  input  logic [W-1:0] dbg_wdata,
  output logic [W-1:0] dbg_rdata
);
  logic         swap;
  logic         usp_wr_ok;
  logic         usp_rd_ok;
  logic [W-1:0] live_q;
  logic [W-1:0] idle_q;
  logic [W-1:0] live_view;
  logic [W-1:0] idle_view;

  dsp_mode_track u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_i    (sup_i),
    .cfg_we   (cfg_we),
    .cfg_eusp (cfg_eusp),
    .dual_en  (dual_en),
    .swap     (swap)
  );

  dsp_priv_check u_priv (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_i      (sup_i),
    .usp_wr_req (usp_wr_req),
    .usp_rd_req (usp_rd_req),
    .usp_wr_ok  (usp_wr_ok),
    .usp_rd_ok  (usp_rd_ok),
    .priv_viol  (priv_viol)
  );

  dsp_regfile #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap       (swap),
    .live_we    (a7_we),
    .live_wdata (a7_wdata),
    .idle_we    (usp_wr_ok),
    .idle_wdata (usp_wdata),
    .dbg_we     (dbg_we),
    .dbg_sel    (dbg_sel),
    .dbg_wdata  (dbg_wdata),
    .live_q     (live_q),
    .idle_q     (idle_q),
    .live_view  (live_view),
    .idle_view  (idle_view)
  );

  assign a7_rdata  = live_view;
  assign usp_rdata = usp_rd_ok ? idle_view : '0;
  assign dbg_rdata = (dbg_sel == SLOT_IDLE) ? idle_q : live_q;
endmodule

// File: rtl/dual_sp_regs_checker.sv
module dual_sp_regs_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sup_i,
  input logic         dual_en,
  input logic         swap,
  input logic         a7_we,
  input logic [W-1:0] a7_wdata,
  input logic         usp_wr_req,
  input logic         usp_rd_req,
  input logic         dbg_we,
  input logic         dbg_sel,
  input logic [W-1:0] dbg_wdata,
  input logic         priv_viol,
  input logic [W-1:0] live_q,
  input logic [W-1:0] idle_q
);
  // R3: with no write traffic, an exchange swaps the two registers
  a_r3_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !a7_we && !dbg_we && !usp_wr_req)
    |=> (live_q == $past(idle_q)) && (idle_q == $past(live_q)));

  // R3: an A7 write on the exchange edge lands in the post-exchange live register
  a_r3_write_post_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && a7_we && !dbg_we) |=> live_q == $past(a7_wdata));

  // R4: with the enable clear and no writes, both registers hold
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_en && !a7_we && !dbg_we && !usp_wr_req)
    |=> $stable(live_q) && $stable(idle_q));

  // R6: a user-mode move raises the violation pulse on the next cycle
  a_r6_viol: assert property (@(posedge clk) disable iff (!rst_n)
    ((usp_wr_req || usp_rd_req) && !sup_i) |=> priv_viol);

  // R6: no violation follows a supervisor-mode cycle
  a_r6_no_false_viol: assert property (@(posedge clk) disable iff (!rst_n)
    sup_i |=> !priv_viol);

  // R6: a refused move changes neither register
  a_r6_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (usp_wr_req && !sup_i && !swap && !a7_we && !dbg_we)
    |=> $stable(live_q) && $stable(idle_q));

  // R8: debug data wins over a same-cycle core write to the live register
  a_r8_dbg_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && !dbg_sel && a7_we) |=> live_q == $past(dbg_wdata));
endmodule

bind dual_sp_regs dual_sp_regs_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sup_i      (sup_i),
  .dual_en    (dual_en),
  .swap       (swap),
  .a7_we      (a7_we),
  .a7_wdata   (a7_wdata),
  .usp_wr_req (usp_wr_req),
  .usp_rd_req (usp_rd_req),
  .dbg_we     (dbg_we),
  .dbg_sel    (dbg_sel),
  .dbg_wdata  (dbg_wdata),
  .priv_viol  (priv_viol),
  .live_q     (live_q),
  .idle_q     (idle_q)
);

// File: tb/dual_sp_regs_tb.sv
module dual_sp_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup_i = 1'b1;
  logic        cfg_we = 1'b0, cfg_eusp = 1'b0;
  logic        dual_en;
  logic        a7_we = 1'b0;
  logic [31:0] a7_wdata = '0;
  logic [31:0] a7_rdata;
  logic        usp_wr_req = 1'b0, usp_rd_req = 1'b0;
  logic [31:0] usp_wdata = '0;
  logic [31:0] usp_rdata;
  logic        priv_viol;
  logic        dbg_we = 1'b0, dbg_sel = 1'b0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_sp_regs u_dut (.*);

  // fields: {sup, a7_we, a7_wdata, expected live, expected inactive}
  localparam logic [97:0] VEC [6] = '{
    {1'b1, 1'b1, 32'h1111_0000, 32'h1111_0000, 32'h0000_0000},
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h1111_0000},
    {1'b0, 1'b1, 32'h2222_0000, 32'h2222_0000, 32'h1111_0000},
    {1'b1, 1'b0, 32'h0000_0000, 32'h1111_0000, 32'h2222_0000},
    {1'b0, 1'b1, 32'h3333_0000, 32'h3333_0000, 32'h1111_0000},
    {1'b1, 1'b0, 32'h0000_0000, 32'h1111_0000, 32'h3333_0000}
  };

  task automatic step;
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    sup_i = 1'b1;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic peek_idle(input logic [31:0] exp, input string tag);
    dbg_sel = 1'b1;
    #1;
    chk(tag, dbg_rdata, exp);
    dbg_sel = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 live", a7_rdata, 32'h0);
    peek_idle(32'h0, "R1 idle");
    chk("R1 dual_en", {31'h0, dual_en}, 32'h0);
    chk("R1 priv_viol", {31'h0, priv_viol}, 32'h0);

    // R4: enable clear, a mode change moves nothing
    a7_we = 1'b1; a7_wdata = 32'hAAAA_5555;
    step();
    a7_we = 1'b0;
    chk("R2 write live", a7_rdata, 32'hAAAA_5555);
    sup_i = 1'b0;
    step();
    chk("R4 live kept", a7_rdata, 32'hAAAA_5555);
    peek_idle(32'h0, "R4 idle kept");

    // R9: enable write
    do_reset();
    cfg_we = 1'b1; cfg_eusp = 1'b1;
    #1;
    chk("R9 not yet", {31'h0, dual_en}, 32'h0);
    step();
    cfg_we = 1'b0;
    chk("R9 dual_en", {31'h0, dual_en}, 32'h1);

    // R2/R3 table
    for (int i = 0; i < 6; i++) begin
      sup_i    = VEC[i][97];
      a7_we    = VEC[i][96];
      a7_wdata = VEC[i][95:64];
      step();
      a7_we = 1'b0;
      chk($sformatf("R3 row%0d live", i), a7_rdata, VEC[i][63:32]);
      peek_idle(VEC[i][31:0], $sformatf("R3 row%0d idle", i));
    end

    // R3: read of the live pointer in the exchange cycle, before the edge
    sup_i = 1'b0;
    #1;
    chk("R3 early view", a7_rdata, 32'h3333_0000);
    step();

    // R6: user-mode moves refused
    usp_wr_req = 1'b1; usp_wdata = 32'hDEAD_BEEF;
    step();
    usp_wr_req = 1'b0;
    chk("R6 viol wr", {31'h0, priv_viol}, 32'h1);
    chk("R6 live kept", a7_rdata, 32'h3333_0000);
    peek_idle(32'h1111_0000, "R6 idle kept");
    step();
    chk("R6 one cycle", {31'h0, priv_viol}, 32'h0);
    usp_rd_req = 1'b1;
    step();
    usp_rd_req = 1'b0;
    chk("R6 viol rd", {31'h0, priv_viol}, 32'h1);

    // R5: supervisor-mode moves use the inactive register
    sup_i = 1'b1;
    step();
    usp_rd_req = 1'b1;
    #1;
    chk("R5 usp read", usp_rdata, 32'h3333_0000);
    usp_rd_req = 1'b0;
    usp_wr_req = 1'b1; usp_wdata = 32'h4444_0000;
    step();
    usp_wr_req = 1'b0;
    peek_idle(32'h4444_0000, "R5 usp write");
    chk("R5 live kept", a7_rdata, 32'h1111_0000);
    chk("R6 no viol in sup", {31'h0, priv_viol}, 32'h0);

    // R7: raw debug access
    dbg_sel = 1'b0;
    #1;
    chk("R7 sel live", dbg_rdata, 32'h1111_0000);
    sup_i = 1'b0;
    step();
    #1;
    chk("R7 live in user", dbg_rdata, 32'h4444_0000);
    peek_idle(32'h1111_0000, "R7 idle in user");
    dbg_we = 1'b1; dbg_sel = 1'b1; dbg_wdata = 32'h7777_0000;
    step();
    dbg_we = 1'b0;
    peek_idle(32'h7777_0000, "R7 dbg write idle");

    // R8: debug beats core on the live register
    a7_we = 1'b1; a7_wdata = 32'h5555_0000;
    dbg_we = 1'b1; dbg_sel = 1'b0; dbg_wdata = 32'h6666_0000;
    step();
    a7_we = 1'b0; dbg_we = 1'b0;
    chk("R8 dbg wins", a7_rdata, 32'h6666_0000);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule